// File: doc/BRIEF.md
# Pin Solder Test Controller

This block gives a board tester a way to prove that every signal pin of the chip is soldered. The mode is requested by holding two active-low test pads low. It takes effect only if the reset pad read high when power-on reset was released. On the clock edge that first sees the request, the block stores the input value of every pad. From the next cycle it turns every pad except the two test pads into an output that drives the stored value back.

One designated pad carries a parity bit. The parity is the XOR of the input value of every pad other than the two test pads and the parity pad itself. An external probe that back-drives any single pad therefore flips the parity pad. Outside the mode the parity tree is gated to a constant, and all pads follow their functional output and enable sources. The pads are modelled as parameterised vectors for input value, output data and output enable.

Top module: `pin_solder_test`

## Requirements
- R1: With the default parameters, the test pads are bits 14 and 15 of `pad_in`. The mode becomes active on the first rising clock edge at which both test pads are 0 and the latched reset qualifier is 1. From that edge onward the pads carry test-mode values.
- R2: While the mode is active, `pad_oe` is 1 on every bit except the two test-pad bits, which are 0.
- R3: At the entry edge the block stores `pad_in`. While the mode is active, every `pad_out` bit other than the parity pad equals the stored value.
- R4: The stored values do not change while the mode stays active, whatever `pad_in` does.
- R5: While the mode is active, `pad_out[7]` (the parity pad) equals the XOR of `pad_in` over all bits except 7, 14 and 15. It follows `pad_in` combinationally, so flipping any one of those bits flips it.
- R6: While the mode is not active, `pad_out` equals `func_out` and `pad_oe` equals `func_oe` on every bit, the parity pad included, for any value of `pad_in`.
- R7: When either test pad goes to 1, the pads return to `func_out` and `func_oe` at the next rising clock edge, not before.
- R8: The reset qualifier is the value of `pad_in[13]` at the first rising clock edge after `por_n` is released. It is held until the next power-on reset. If it was 0, the mode cannot be entered. Driving `pad_in[13]` low during the mode does not end the mode.
- R9: While `por_n` is 0, the mode is inactive and the pads follow the functional sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pad_in | input | N | Input value seen at each pad |
| func_out | input | N | Functional output data for each pad |
| func_oe | input | N | Functional output enable for each pad |
| pad_out | output | N | Output data driven to each pad |
| pad_oe | output | N | Output enable driven to each pad |

## Verification
Two functions can coincide at the entry edge: the capture of `pad_in` and the opening of the parity gate. The bench provokes this by changing pad values in the same cycle that the test pads fall. It then judges the driven vector against the values present at that edge, and judges the parity against the live pad values. A reset-pad pulse is also applied inside the mode, so that a back-drive of the qualifier pad coincides with the mode-hold logic. A reference model checks that the parity toggles while the mode persists.

// File: rtl/pin_solder_test.sv
module pin_solder_test #(
  parameter int N         = 16,
  parameter int TEST0_IDX = 14,
  parameter int TEST1_IDX = 15,
  parameter int RST_IDX   = 13,
  parameter int PAR_IDX   = 7
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] pad_in,
  input  logic [N-1:0] func_out,
  input  logic [N-1:0] func_oe,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);
  localparam logic [N-1:0] ONE       = 1;
  localparam logic [N-1:0] TEST_MASK = (ONE << TEST0_IDX) | (ONE << TEST1_IDX);
  localparam logic [N-1:0] PAR_MASK  = ONE << PAR_IDX;
  localparam logic [N-1:0] XOR_MASK  = ~(TEST_MASK | PAR_MASK);

  logic         rst_lat, lat_done, mode_q, mode_req, parity;
  logic [N-1:0] cap_q, drive_out;

  assign mode_req = ~pad_in[TEST0_IDX] & ~pad_in[TEST1_IDX] & rst_lat;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      rst_lat  <= 1'b0;
      lat_done <= 1'b0;
    end else if (!lat_done) begin
      rst_lat  <= pad_in[RST_IDX];
      lat_done <= 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      mode_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      mode_q <= mode_req;
      if (mode_req && !mode_q) cap_q <= pad_in;
    end

  assign parity    = ^(pad_in & XOR_MASK & {N{mode_q}});
  assign drive_out = (cap_q & ~PAR_MASK) | (parity ? PAR_MASK : '0);
  assign pad_out   = mode_q ? drive_out : func_out;
  assign pad_oe    = mode_q ? ~TEST_MASK : func_oe;
endmodule

// File: rtl/pin_solder_test_chk.sv
module pin_solder_test_chk #(
  parameter int N         = 16,
  parameter int TEST0_IDX = 14,
  parameter int TEST1_IDX = 15,
  parameter int PAR_IDX   = 7
) (
  input logic         clk,
  input logic         por_n,
  input logic [N-1:0] pad_in,
  input logic [N-1:0] func_out,
  input logic [N-1:0] func_oe,
  input logic [N-1:0] pad_out,
  input logic [N-1:0] pad_oe,
  input logic         mode_q,
  input logic         rst_lat,
  input logic         lat_done
);
  localparam logic [N-1:0] ONE = 1;
  localparam logic [N-1:0] TM  = (ONE << TEST0_IDX) | (ONE << TEST1_IDX);
  localparam logic [N-1:0] PM  = ONE << PAR_IDX;

  assert_enter_R1: assert property (@(posedge clk) disable iff (!por_n)
    (!pad_in[TEST0_IDX] && !pad_in[TEST1_IDX] && rst_lat) |=> mode_q);

  assert_oe_R2: assert property (@(posedge clk) disable iff (!por_n)
    mode_q |-> (pad_oe == ~TM));

  assert_capture_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(mode_q) |-> ((pad_out & ~PM) == ($past(pad_in) & ~PM)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
    (mode_q && $past(mode_q)) |-> $stable(pad_out & ~PM));

  assert_exit_R7: assert property (@(posedge clk) disable iff (!por_n)
    (pad_in[TEST0_IDX] || pad_in[TEST1_IDX]) |=> (pad_out == func_out && pad_oe == func_oe));

  assert_latch_R8: assert property (@(posedge clk) disable iff (!por_n)
    (lat_done && $past(lat_done)) |-> $stable(rst_lat));
endmodule

bind pin_solder_test pin_solder_test_chk #(
  .N(N), .TEST0_IDX(TEST0_IDX), .TEST1_IDX(TEST1_IDX), .PAR_IDX(PAR_IDX)
) u_chk (
  .clk(clk), .por_n(por_n), .pad_in(pad_in), .func_out(func_out), .func_oe(func_oe),
  .pad_out(pad_out), .pad_oe(pad_oe), .mode_q(mode_q), .rst_lat(rst_lat), .lat_done(lat_done)
);

// File: tb/pin_solder_test_tb.sv
`timescale 1ns/1ps
module pin_solder_test_tb;
  localparam int N = 16, T0 = 14, T1 = 15, RI = 13, PI = 7;
  localparam logic [N-1:0] ONE = 1;
  localparam logic [N-1:0] TM  = (ONE << T0) | (ONE << T1);
  localparam logic [N-1:0] PM  = ONE << PI;
  localparam logic [N-1:0] XM  = ~(TM | PM);

  logic clk = 0, por_n = 0;
  logic [N-1:0] pad_in, func_out, func_oe, pad_out, pad_oe;
  int tests = 0, fails = 0;
  logic m_lat, m_done, m_mode;
  logic [N-1:0] m_cap;

  always #2.5 clk = ~clk;

  pin_solder_test u_dut (.clk(clk), .por_n(por_n), .pad_in(pad_in), .func_out(func_out),
    .func_oe(func_oe), .pad_out(pad_out), .pad_oe(pad_oe));

  function automatic logic exp_par(input logic [N-1:0] p);
    return ^(p & XM);
  endfunction
  function automatic logic [N-1:0] exp_out();
    if (!m_mode) return func_out;
    return (m_cap & ~PM) | (exp_par(pad_in) ? PM : '0);
  endfunction
  function automatic logic [N-1:0] exp_oe();
    return m_mode ? ~TM : func_oe;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_pads(input string req);
    check({req, " out"}, pad_out, exp_out());
    check({req, " oe"}, pad_oe, exp_oe());
  endtask

  task automatic step();
    logic nl, nd, nm;
    logic [N-1:0] nc;
    nl = m_lat; nd = m_done; nc = m_cap;
    if (!m_done) begin nl = pad_in[RI]; nd = 1; end
    nm = !pad_in[T0] && !pad_in[T1] && m_lat;
    if (nm && !m_mode) nc = pad_in;
    @(posedge clk);
    m_lat = nl; m_done = nd; m_mode = nm; m_cap = nc;
    #1;
  endtask

  task automatic do_por(input logic rst_pin);
    por_n = 0;
    pad_in = 16'hc000 | (rst_pin ? (ONE << RI) : '0);
    m_lat = 0; m_done = 0; m_mode = 0; m_cap = '0;
    #1;
    check("R9 reset", pad_out, func_out);
    check("R9 reset oe", pad_oe, func_oe);
    #7;
    por_n = 1;
    step();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic prev;
    void'($urandom(32'd4242));
    func_out = 16'h5a3c; func_oe = 16'h0ff0;
    do_por(1'b1);
    for (int i = 0; i < 8; i++) begin
      pad_in = ($urandom() & ~TM) | TM | (ONE << RI);
      func_out = $urandom(); func_oe = $urandom();
      #1; check_pads("R6 idle");
      step(); check_pads("R6 idle");
    end
    // entry with pad values changing in the same cycle
    pad_in = ($urandom() & ~TM) | (ONE << RI);
    #1; check_pads("R7 before edge");
    step();
    check_pads("R1 R3 entry");
    check("R2 oe", pad_oe, ~TM);
    for (int i = 0; i < 40; i++) begin
      int b;
      prev = pad_out[PI];
      do b = $urandom_range(N-1); while (b == T0 || b == T1 || b == PI);
      pad_in[b] = ~pad_in[b];
      func_out = $urandom(); func_oe = $urandom();
      #1;
      check("R5 toggle", {15'd0, pad_out[PI]}, {15'd0, ~prev});
      check_pads("R5 parity");
      step(); check_pads("R4 hold");
    end
    pad_in[RI] = 1'b0; step(); check_pads("R8 reset pad pulse");
    check("R8 mode kept", pad_oe, ~TM);
    pad_in[RI] = 1'b1; step(); check_pads("R8 reset pad back");
    pad_in[T0] = 1'b1; #1; check("R7 no early exit", pad_oe, ~TM);
    step(); check_pads("R7 exit");
    check("R7 exit oe", pad_oe, func_oe);
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(3) == 0) pad_in = $urandom();
      else pad_in = (pad_in & TM) | ($urandom() & ~TM);
      func_out = $urandom(); func_oe = $urandom();
      #1; check_pads("R5 R6 random");
      step(); check_pads("R1 R4 R7 random");
    end
    do_por(1'b0);
    pad_in = $urandom() & ~TM;
    step(); step(); check_pads("R8 qualifier low");
    check("R8 no entry", pad_oe, func_oe);
    do_por(1'b1);
    pad_in = ($urandom() & ~TM) | (ONE << RI);
    step(); check("R3 re-entry", pad_out & ~PM, m_cap & ~PM);
    check_pads("R1 re-entry");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule